// File: doc/BRIEF.md
# Drawing Engine Pixel Address Unit

This block turns a pixel coordinate into a memory location for a 2-D drawing engine. From a coordinate (x, y), the display mode, the image width and the colour depth, it forms the logical byte address of the pixel and the bit position of the pixel inside that byte. The leftmost pixel of a byte sits in the most significant bits.

The two character-style modes use a fixed layout at 4 bits per pixel and ignore the width and depth settings. The bitmap mode and the standby mode use the programmed width and depth. A pixel-set request always uses the bitmap layout and reads nothing from memory.

A point-read request issues one memory read. The memory returns data one cycle later. The unit then returns the pixel left-justified in the low data byte, with the remaining low bits cleared. Requests are accepted every cycle.

Top module: `pix_addr_unit`

## Requirements
- R1: After reset, `addr_valid`, `mem_rd` and `rsp_valid` are 0.
- R2: Mode 0 (first fixed mode) uses 4 bits per pixel and 256 pixels per row. The address is y*128 + x/2, whatever `width_sel` and `depth_sel` hold.
- R3: Mode 1 (second fixed mode) uses 4 bits per pixel and 512 pixels per row. The address is y*256 + x/2, whatever `width_sel` and `depth_sel` hold.
- R4: Mode 2 (bitmap) uses the programmed settings. The row width is 256 << `width_sel` pixels, and the depth is 2 << `depth_sel` bits per pixel (0=2, 1=4, 2=8, 3=16). The address is (y*width + x)*bpp/8, taken modulo 2^AW.
- R5: Mode 3 (standby) computes the same address and bit position as mode 2.
- R6: When `req_set`=1, the unit uses the mode-2 layout whatever `req_mode` holds. It asserts no memory read and gives no response.
- R7: `addr_valid` rises in the cycle after a request. `mem_rd` rises in that same cycle for a point read. `rsp_valid` follows `mem_rd` by one cycle.
- R8: A 2-bpp point read returns the selected pixel in `rsp_data[7:6]`, with all other bits 0. The byte offset x mod 4 = 0..3 selects bits 7:6, 5:4, 3:2 or 1:0 of the byte.
- R9: A 4-bpp point read returns the selected nibble in `rsp_data[7:4]`, with all other bits 0. Even x selects the high nibble.
- R10: An 8-bpp point read returns the byte in `rsp_data[7:0]` with the upper byte 0. A 16-bpp point read returns the whole 16-bit word.
- R11: `addr_bitpos` is the lowest bit index of the pixel within its byte, which is 8 - bpp - (bit offset from the MSB). It is 0 for 8 and 16 bpp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_set | input | 1 | 1 = pixel-set address only, 0 = point read |
| req_x | input | XW | Pixel x coordinate |
| req_y | input | YW | Pixel y coordinate |
| req_mode | input | 2 | 0 first fixed, 1 second fixed, 2 bitmap, 3 standby |
| width_sel | input | 2 | Row width 256 << n pixels |
| depth_sel | input | 2 | Depth 2 << n bits per pixel |
| addr_valid | output | 1 | Address outputs valid |
| addr_out | output | AW | Logical byte address, also the memory read address |
| addr_bitpos | output | 3 | Lowest bit of the pixel within the byte |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Memory data, one cycle after `mem_rd` |
| rsp_valid | output | 1 | Point-read result valid |
| rsp_data | output | 16 | Left-justified pixel |

## Verification
The bench crosses all four modes, all four widths, all four depths and both request kinds. Each combination is tried over a set of coordinates chosen to cover every sub-byte offset and several row numbers.

The crossing against the fixed modes shows whether the width and depth settings are really ignored there. The crossing against pixel-set requests shows whether the bitmap layout is forced. The odd and even x values separate left-justification from plain right-aligned extraction. The varying memory contents show whether the correct field is picked out of the byte.

// File: rtl/pix_addr_unit.sv
module pix_addr_unit #(
  parameter int AW = 19,
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_set,
  input  logic [XW-1:0] req_x,
  input  logic [YW-1:0] req_y,
  input  logic [1:0]    req_mode,
  input  logic [1:0]    width_sel,
  input  logic [1:0]    depth_sel,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out,
  output logic [2:0]    addr_bitpos,
  output logic          mem_rd,
  input  logic [15:0]   mem_rdata,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data
);
  localparam int BW = AW + 3;

  logic          use_bitmap;
  logic [3:0]    wlog;
  logic [2:0]    blog;
  logic [BW-1:0] pix_idx, bit_addr;
  logic [2:0]    off_q, off2_q, blog_q, blog2_q;
  logic [7:0]    lj;

  assign use_bitmap = req_set | req_mode[1];
  assign wlog = use_bitmap ? 4'd8 + {2'b0, width_sel} : (req_mode[0] ? 4'd9 : 4'd8);
  assign blog = use_bitmap ? {1'b0, depth_sel} + 3'd1 : 3'd2;

  assign pix_idx  = (BW'(req_y) << wlog) + BW'(req_x);
  assign bit_addr = pix_idx << blog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      mem_rd     <= 1'b0;
      rsp_valid  <= 1'b0;
      addr_out   <= '0;
      off_q      <= '0;
      blog_q     <= 3'd1;
      off2_q     <= '0;
      blog2_q    <= 3'd1;
    end else begin
      addr_valid <= req_valid;
      mem_rd     <= req_valid & ~req_set;
      rsp_valid  <= mem_rd;
      if (req_valid) begin
        addr_out <= bit_addr[BW-1:3];
        off_q    <= bit_addr[2:0];
        blog_q   <= blog;
      end
      if (mem_rd) begin
        off2_q  <= off_q;
        blog2_q <= blog_q;
      end
    end
  end

  assign addr_bitpos = (blog_q == 3'd1) ? 3'(3'd6 - off_q) :
                       (blog_q == 3'd2) ? 3'(3'd4 - off_q) : 3'd0;

  assign lj = mem_rdata[7:0] << off2_q;

  always_comb begin
    case (blog2_q)
      3'd1:    rsp_data = {8'h00, lj[7:6], 6'b0};
      3'd2:    rsp_data = {8'h00, lj[7:4], 4'b0};
      3'd3:    rsp_data = {8'h00, mem_rdata[7:0]};
      default: rsp_data = mem_rdata;
    endcase
  end
endmodule

// File: rtl/pix_addr_unit_chk.sv
module pix_addr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_set,
  input logic [1:0]  req_mode,
  input logic [1:0]  depth_sel,
  input logic        addr_valid,
  input logic [2:0]  addr_bitpos,
  input logic        mem_rd,
  input logic        rsp_valid,
  input logic [15:0] rsp_data
);
  assert_addr_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  assert_rsp_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> rsp_valid);
  assert_rsp_has_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd));
  assert_set_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(req_set)) |-> !mem_rd);
  assert_2bpp_justified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_mode[1], 2) && $past(depth_sel, 2) == 2'd0)
      |-> (rsp_data & 16'hFF3F) == 16'h0);
  assert_4bpp_justified_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_mode[1], 2))
      |-> (rsp_data & 16'hFF0F) == 16'h0);
  assert_wide_bitpos_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && ($past(req_mode[1]) || $past(req_set)) && $past(depth_sel[1]))
      |-> addr_bitpos == 3'd0);
endmodule

bind pix_addr_unit pix_addr_unit_chk u_chk (.*);

// File: tb/tb_pix_addr_unit.sv
module tb_pix_addr_unit;
  localparam int AW = 19;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_set = 1'b0;
  logic [10:0] req_x = '0, req_y = '0;
  logic [1:0] req_mode = '0, width_sel = '0, depth_sel = '0;
  logic addr_valid, mem_rd, rsp_valid;
  logic [AW-1:0] addr_out;
  logic [2:0] addr_bitpos;
  logic [15:0] mem_rdata = '0, rsp_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pix_addr_unit #(.AW(AW), .XW(11), .YW(11)) dut (.*);

  function automatic logic [15:0] mem_word(input int a);
    return {8'(a) + 8'h3C, 8'(a >> 8) ^ 8'(a) ^ 8'hA5};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_word(int'(addr_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input int mode, input int ws, input int ds, input int set, input int x, input int y);
    int w, bpp, bits, ea, off, ebp, byt, ed;
    string tg;
    if (set != 0 || mode >= 2) begin w = 256 << ws; bpp = 2 << ds; end
    else begin w = (mode == 1) ? 512 : 256; bpp = 4; end
    bits = (y * w + x) * bpp;
    ea = (bits / 8) % (1 << AW);
    off = bits % 8;
    ebp = (bpp < 8) ? 8 - bpp - off : 0;
    byt = int'(mem_word(ea) & 16'h00FF);
    if (bpp == 2) ed = ((byt >> (6 - off)) & 3) << 6;
    else if (bpp == 4) ed = ((byt >> (4 - off)) & 15) << 4;
    else if (bpp == 8) ed = byt;
    else ed = int'(mem_word(ea));
    tg = set != 0 ? "R6" : (mode == 0 ? "R2" : mode == 1 ? "R3" : mode == 2 ? "R4" : "R5");
    req_valid = 1'b1; req_set = 1'(set); req_mode = 2'(mode);
    width_sel = 2'(ws); depth_sel = 2'(ds); req_x = 11'(x); req_y = 11'(y);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R7 addr_valid", int'(addr_valid), 1);
    chk("R7/R6 mem_rd", int'(mem_rd), set != 0 ? 0 : 1);
    chk({tg, " addr"}, int'(addr_out), ea);
    chk("R11 bitpos", int'(addr_bitpos), ebp);
    @(posedge clk); @(negedge clk);
    chk("R7/R6 rsp_valid", int'(rsp_valid), set != 0 ? 0 : 1);
    if (set == 0)
      chk(bpp == 2 ? "R8 data" : bpp == 4 ? "R9 data" : "R10 data", int'(rsp_data), ed);
  endtask

  initial begin
    int xs[8] = '{0, 1, 2, 3, 5, 127, 200, 255};
    int ys[5] = '{0, 1, 3, 17, 255};
    repeat (3) @(negedge clk);
    chk("R1 addr_valid", int'(addr_valid), 0);
    chk("R1 mem_rd", int'(mem_rd), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int ws = 0; ws < 4; ws++)
        for (int ds = 0; ds < 4; ds++)
          for (int s = 0; s < 2; s++)
            for (int xi = 0; xi < 8; xi++)
              for (int yi = 0; yi < 5; yi++)
                run_one(m, ws, ds, s, xs[xi], ys[yi]);
    run_one(2, 3, 3, 0, 2047, 2047);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule